// File: doc/BRIEF.md
# Interrupt Source Table

This block is the source side of a message-signalled interrupt controller. It keeps one entry per interrupt source: the server the source is routed to, its priority, a flag showing that the source fired while it was masked, and a flag showing that the presentation layer turned it away. A source is addressed by a global number. The table covers the numbers from a base offset up to the base plus the source count. A priority of 0xFF means the source is masked.

A trigger pulse on an unmasked source produces a present request that carries the server, the global number and the priority. A trigger on a masked source is held until software unmasks the source. The presentation layer can hand a source back by sending a reject notification. It can later send a resend request, which makes the table walk all entries in index order and present again every rejected source that is unmasked. The table has one configuration port. This port writes an entry's server and priority, or reads them back, and returns a status code for each operation.

Top module: `irq_src_table`

## Requirements
- R1: After reset every entry has priority 0xFF and server 0, busy and pres_valid are low, and a read of any valid source returns status 0x00, server 0 and priority 0xFF.
- R2: A source number is accepted only when BASE <= number < BASE+NSRC, and the entry it selects has index number-BASE. A configuration operation on any other number returns status 0xFD (-3 in 8 bits) one cycle after cfg_valid, and returns server and priority as 0.
- R3: A trigger on an entry whose priority is 0xFF raises no present request. Instead it records a pending flag.
- R4: A trigger on an entry whose priority is not 0xFF raises exactly one present request in the next cycle. The request carries the stored server, the number BASE+index and the stored priority.
- R5: A valid configuration write stores the server and the priority and returns status 0x00 one cycle after cfg_valid. A later read returns the stored values with status 0x00.
- R6: A valid write with priority other than 0xFF to an entry whose pending flag is set clears the flag and presents the entry in the next cycle with the new server and priority. A second write does not present the entry again.
- R7: A write whose server is not below NSERVERS, or whose 9-bit priority is above 0xFF, returns status 0xFD and leaves the entry unchanged. A priority of exactly 0xFF is accepted.
- R8: A reject notification for a valid number sets the rejected flag of that entry. A reject notification for an invalid number is ignored.
- R9: A resend request starts a scan in index order. During the scan, each rejected entry whose priority is not 0xFF is presented, at most one per cycle, and its rejected flag is cleared. A second resend therefore presents nothing.
- R10: During a scan, a rejected entry whose priority is 0xFF is not presented and stays rejected. It is presented by a later scan once it has been unmasked.
- R11: busy goes high in the cycle after a resend request is accepted, and stays high for NSRC cycles when nothing stalls the scan. Each cycle in which a trigger or a write takes the present output holds the scan on its current entry for one more cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger pulse for one source |
| trig_idx | input | IDX_W | Table index of the triggered source |
| rej_valid | input | 1 | Reject notification from the presentation layer |
| rej_num | input | NUM_W | Global number of the rejected source |
| resend_req | input | 1 | Request a replay scan of rejected sources |
| cfg_valid | input | 1 | Configuration operation strobe |
| cfg_write | input | 1 | 1 = write entry, 0 = read entry |
| cfg_num | input | NUM_W | Global source number to configure |
| cfg_server | input | SRVIN_W | Server to write |
| cfg_prio | input | 9 | Priority to write (values above 0xFF are rejected) |
| cfg_done | output | 1 | Configuration response valid |
| cfg_status | output | 8 | 0x00 success, 0xFD invalid argument |
| cfg_rd_server | output | SRV_W | Server returned by a read |
| cfg_rd_prio | output | 8 | Priority returned by a read |
| pres_valid | output | 1 | Present request valid |
| pres_server | output | SRV_W | Target server of the request |
| pres_num | output | NUM_W | Global number of the presented source |
| pres_prio | output | 8 | Priority of the presented source |
| busy | output | 1 | Resend scan in progress |

## Verification
The assertions rely on one condition about the inputs: trig_valid and cfg_valid are never high in the same cycle, so that at most one foreground present competes with the scan. They also rely on resend_req being seen only when the block is idle. The bench keeps to both conditions. Every scenario task issues a single kind of request per cycle, and the tasks wait for busy to fall before they request another scan. Triggers are injected in the middle of a scan only from the dedicated stall scenario.

// File: rtl/irq_src_table.sv
module irq_src_table #(
  parameter int NSRC     = 16,
  parameter int BASE     = 32,
  parameter int NSERVERS = 4,
  parameter int NUM_W    = 12,
  parameter int SRVIN_W  = 8,
  localparam int IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int SRV_W   = (NSERVERS > 1) ? $clog2(NSERVERS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_valid,
  input  logic [IDX_W-1:0]   trig_idx,
  input  logic               rej_valid,
  input  logic [NUM_W-1:0]   rej_num,
  input  logic               resend_req,
  input  logic               cfg_valid,
  input  logic               cfg_write,
  input  logic [NUM_W-1:0]   cfg_num,
  input  logic [SRVIN_W-1:0] cfg_server,
  input  logic [8:0]         cfg_prio,
  output logic               cfg_done,
  output logic [7:0]         cfg_status,
  output logic [SRV_W-1:0]   cfg_rd_server,
  output logic [7:0]         cfg_rd_prio,
  output logic               pres_valid,
  output logic [SRV_W-1:0]   pres_server,
  output logic [NUM_W-1:0]   pres_num,
  output logic [7:0]         pres_prio,
  output logic               busy
);

  localparam logic [7:0] MASKED  = 8'hFF;
  localparam logic [7:0] ST_OK   = 8'h00;
  localparam logic [7:0] ST_BAD  = 8'hFD;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSRC - 1);

  logic [SRV_W-1:0] srv_q [NSRC];
  logic [7:0]       pri_q [NSRC];
  logic [NSRC-1:0]  pend_q;
  logic [NSRC-1:0]  rej_q;
  logic [IDX_W-1:0] scan_idx;

  function automatic logic in_rng(input logic [NUM_W-1:0] n);
    return (int'(n) >= BASE) && (int'(n) < BASE + NSRC);
  endfunction

  logic [IDX_W-1:0] cfg_idx, rej_idx;
  assign cfg_idx = IDX_W'(cfg_num - NUM_W'(BASE));
  assign rej_idx = IDX_W'(rej_num - NUM_W'(BASE));

  logic cfg_num_ok, cfg_wr_ok, trig_ok, trig_pres, wr_pres, fg_pres;
  logic scan_hit, scan_pres, scan_go;

  assign cfg_num_ok = in_rng(cfg_num);
  assign cfg_wr_ok  = cfg_valid && cfg_write && cfg_num_ok
                      && (int'(cfg_server) < NSERVERS) && (cfg_prio <= 9'h0FF);
  assign trig_ok    = trig_valid && (int'(trig_idx) < NSRC);
  assign trig_pres  = trig_ok && (pri_q[trig_idx] != MASKED);
  assign wr_pres    = cfg_wr_ok && pend_q[cfg_idx] && (cfg_prio[7:0] != MASKED);
  assign fg_pres    = trig_pres || wr_pres;
  assign scan_hit   = busy && rej_q[scan_idx] && (pri_q[scan_idx] != MASKED);
  assign scan_pres  = scan_hit && !fg_pres;
  assign scan_go    = busy && !fg_pres;

  // Entry table
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        srv_q[i] <= '0;
        pri_q[i] <= MASKED;
      end
      pend_q <= '0;
      rej_q  <= '0;
    end else begin
      if (trig_ok && (pri_q[trig_idx] == MASKED))
        pend_q[trig_idx] <= 1'b1;
      if (cfg_wr_ok) begin
        srv_q[cfg_idx] <= cfg_server[SRV_W-1:0];
        pri_q[cfg_idx] <= cfg_prio[7:0];
        if (wr_pres)
          pend_q[cfg_idx] <= 1'b0;
      end
      if (scan_pres)
        rej_q[scan_idx] <= 1'b0;
      if (rej_valid && in_rng(rej_num))
        rej_q[rej_idx] <= 1'b1;
    end
  end

  // Present output
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_valid  <= 1'b0;
      pres_server <= '0;
      pres_num    <= '0;
      pres_prio   <= '0;
    end else begin
      pres_valid <= fg_pres || scan_pres;
      if (trig_pres) begin
        pres_server <= srv_q[trig_idx];
        pres_num    <= NUM_W'(BASE) + NUM_W'(trig_idx);
        pres_prio   <= pri_q[trig_idx];
      end else if (wr_pres) begin
        pres_server <= cfg_server[SRV_W-1:0];
        pres_num    <= cfg_num;
        pres_prio   <= cfg_prio[7:0];
      end else if (scan_pres) begin
        pres_server <= srv_q[scan_idx];
        pres_num    <= NUM_W'(BASE) + NUM_W'(scan_idx);
        pres_prio   <= pri_q[scan_idx];
      end
    end
  end

  // Resend scan
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      scan_idx <= '0;
    end else if (busy) begin
      if (scan_go) begin
        if (scan_idx == LAST_IDX) begin
          busy     <= 1'b0;
          scan_idx <= '0;
        end else begin
          scan_idx <= scan_idx + 1'b1;
        end
      end
    end else if (resend_req) begin
      busy     <= 1'b1;
      scan_idx <= '0;
    end
  end

  // Configuration response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_done      <= 1'b0;
      cfg_status    <= ST_OK;
      cfg_rd_server <= '0;
      cfg_rd_prio   <= '0;
    end else begin
      cfg_done <= cfg_valid;
      if (cfg_valid) begin
        cfg_rd_server <= '0;
        cfg_rd_prio   <= '0;
        if (cfg_write) begin
          cfg_status <= cfg_wr_ok ? ST_OK : ST_BAD;
        end else if (cfg_num_ok) begin
          cfg_status    <= ST_OK;
          cfg_rd_server <= srv_q[cfg_idx];
          cfg_rd_prio   <= pri_q[cfg_idx];
        end else begin
          cfg_status <= ST_BAD;
        end
      end
    end
  end

  assert_never_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> pres_prio != MASKED);

  assert_num_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> in_rng(pres_num));

  assert_trig_cfg_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_valid && cfg_valid));

  assert_pend_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pres |=> !pend_q[$past(cfg_idx)]);

  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(resend_req));

  assert_busy_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(scan_idx) == LAST_IDX);

  assert_scan_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && scan_idx == $past(scan_idx)) |-> $past(fg_pres));

endmodule

// File: tb/sim_irq_src_table.sv
module sim_irq_src_table;
  localparam int NSRC = 16, BASE = 32, NSERVERS = 4, NUM_W = 12, SRVIN_W = 8;
  localparam int IDX_W = 4, SRV_W = 2;

  logic clk = 0, rst_n = 0;
  logic trig_valid = 0; logic [IDX_W-1:0] trig_idx = '0;
  logic rej_valid = 0;  logic [NUM_W-1:0] rej_num = '0;
  logic resend_req = 0;
  logic cfg_valid = 0, cfg_write = 0;
  logic [NUM_W-1:0] cfg_num = '0; logic [SRVIN_W-1:0] cfg_server = '0; logic [8:0] cfg_prio = '0;
  logic cfg_done; logic [7:0] cfg_status; logic [SRV_W-1:0] cfg_rd_server; logic [7:0] cfg_rd_prio;
  logic pres_valid; logic [SRV_W-1:0] pres_server; logic [NUM_W-1:0] pres_num; logic [7:0] pres_prio;
  logic busy;

  int checks = 0, errors = 0, cycles = 0;
  int q_srv[$], q_num[$], q_pri[$];

  always #5 clk = ~clk;

  irq_src_table #(.NSRC(NSRC), .BASE(BASE), .NSERVERS(NSERVERS), .NUM_W(NUM_W), .SRVIN_W(SRVIN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_idx(trig_idx),
    .rej_valid(rej_valid), .rej_num(rej_num), .resend_req(resend_req),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_num(cfg_num),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cfg_done(cfg_done),
    .cfg_status(cfg_status), .cfg_rd_server(cfg_rd_server), .cfg_rd_prio(cfg_rd_prio),
    .pres_valid(pres_valid), .pres_server(pres_server), .pres_num(pres_num),
    .pres_prio(pres_prio), .busy(busy));

  always @(posedge clk) begin
    #1;
    if (rst_n && pres_valid) begin
      q_srv.push_back(int'(pres_server));
      q_num.push_back(int'(pres_num));
      q_pri.push_back(int'(pres_prio));
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
        finish_run();
      end
    end
  end

  task automatic clear_q; q_srv.delete(); q_num.delete(); q_pri.delete(); endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic cfg_op(input bit wr, input int num, input int srv, input int pri,
                        output int st, output int rs, output int rp);
    @(negedge clk);
    cfg_valid = 1; cfg_write = wr; cfg_num = NUM_W'(num);
    cfg_server = SRVIN_W'(srv); cfg_prio = 9'(pri);
    @(posedge clk); #1;
    st = int'(cfg_status); rs = int'(cfg_rd_server); rp = int'(cfg_rd_prio);
    if (!cfg_done) begin checks++; errors++; $display("FAIL R5: actual cfg_done 0 expected 1"); end
    @(negedge clk); cfg_valid = 0; cfg_write = 0;
  endtask

  task automatic trig(input int idx);
    @(negedge clk); trig_valid = 1; trig_idx = IDX_W'(idx);
    @(negedge clk); trig_valid = 0;
  endtask

  task automatic reject(input int num);
    @(negedge clk); rej_valid = 1; rej_num = NUM_W'(num);
    @(negedge clk); rej_valid = 0;
  endtask

  task automatic resend(input int stall_at, output int nbusy);
    @(negedge clk); resend_req = 1;
    @(posedge clk); #1; nbusy = 0;
    @(negedge clk); resend_req = 0;
    while (busy) begin
      if (nbusy == stall_at) begin trig_valid = 1; trig_idx = 4'd7; end
      nbusy++;
      @(posedge clk); #1;
      @(negedge clk); trig_valid = 0;
    end
  endtask

  task automatic t_reset;
    int st, rs, rp;
    chk("R1 busy", int'(busy), 0);
    chk("R1 pres_valid", int'(pres_valid), 0);
    cfg_op(0, BASE + 5, 0, 0, st, rs, rp);
    chk("R1 status", st, 0); chk("R1 server", rs, 0); chk("R1 prio", rp, 255);
  endtask

  task automatic t_range;
    int st, rs, rp;
    cfg_op(0, BASE - 1, 0, 0, st, rs, rp);          chk("R2 below", st, 253);
    chk("R2 below prio", rp, 0);
    cfg_op(0, BASE + NSRC, 0, 0, st, rs, rp);       chk("R2 above", st, 253);
    cfg_op(0, BASE + NSRC - 1, 0, 0, st, rs, rp);   chk("R2 last", st, 0);
    cfg_op(1, BASE + NSRC, 1, 4, st, rs, rp);       chk("R2 write above", st, 253);
  endtask

  task automatic t_masked_unmask;
    int st, rs, rp;
    clear_q();
    trig(3); idle(3);
    chk("R3 no present", q_num.size(), 0);
    cfg_op(1, BASE + 3, 2, 5, st, rs, rp); idle(2);
    chk("R6 status", st, 0);
    chk("R6 count", q_num.size(), 1);
    if (q_num.size() == 1) begin
      chk("R6 server", q_srv[0], 2); chk("R6 num", q_num[0], BASE + 3); chk("R6 prio", q_pri[0], 5);
    end
    clear_q();
    cfg_op(1, BASE + 3, 2, 6, st, rs, rp); idle(2);
    chk("R6 no repeat", q_num.size(), 0);
    cfg_op(0, BASE + 3, 0, 0, st, rs, rp);
    chk("R5 rd server", rs, 2); chk("R5 rd prio", rp, 6);
  endtask

  task automatic t_trigger;
    int st, rs, rp;
    cfg_op(1, BASE + 7, 1, 16, st, rs, rp);
    chk("R5 write status", st, 0);
    clear_q();
    trig(7); idle(2);
    chk("R4 count", q_num.size(), 1);
    if (q_num.size() == 1) begin
      chk("R4 server", q_srv[0], 1); chk("R4 num", q_num[0], BASE + 7); chk("R4 prio", q_pri[0], 16);
    end
  endtask

  task automatic t_bad_write;
    int st, rs, rp;
    cfg_op(1, BASE + 7, NSERVERS, 9, st, rs, rp);  chk("R7 bad server", st, 253);
    cfg_op(1, BASE + 7, 0, 256, st, rs, rp);       chk("R7 bad prio", st, 253);
    cfg_op(0, BASE + 7, 0, 0, st, rs, rp);
    chk("R7 kept server", rs, 1); chk("R7 kept prio", rp, 16);
    cfg_op(1, BASE + 10, 3, 255, st, rs, rp);      chk("R7 prio FF ok", st, 0);
    cfg_op(0, BASE + 10, 0, 0, st, rs, rp);        chk("R7 FF stored server", rs, 3);
  endtask

  task automatic t_resend;
    int st, rs, rp, nb;
    cfg_op(1, BASE + 2, 3, 20, st, rs, rp);
    cfg_op(1, BASE + 9, 0, 1, st, rs, rp);
    cfg_op(1, BASE + 12, 2, 40, st, rs, rp);
    reject(BASE + 12); reject(BASE + 2); reject(BASE + 9);
    reject(BASE + 5); reject(BASE + NSRC); reject(BASE - 1);
    clear_q();
    resend(-1, nb); idle(2);
    chk("R11 busy length", nb, NSRC);
    chk("R9 count", q_num.size(), 3);
    if (q_num.size() == 3) begin
      chk("R9 first", q_num[0], BASE + 2);  chk("R9 first prio", q_pri[0], 20);
      chk("R9 second", q_num[1], BASE + 9); chk("R9 second server", q_srv[1], 0);
      chk("R9 third", q_num[2], BASE + 12); chk("R9 third server", q_srv[2], 2);
    end
    clear_q();
    resend(-1, nb); idle(2);
    chk("R9 second scan empty", q_num.size(), 0);
    cfg_op(1, BASE + 5, 1, 3, st, rs, rp); idle(2);
    chk("R10 unmask no present", q_num.size(), 0);
    resend(-1, nb); idle(2);
    chk("R10 count", q_num.size(), 1);
    if (q_num.size() == 1) chk("R10 num", q_num[0], BASE + 5);
    clear_q();
    resend(-1, nb); idle(2);
    chk("R8 invalid rejects ignored", q_num.size(), 0);
  endtask

  task automatic t_stall;
    int nb;
    reject(BASE + 2);
    clear_q();
    resend(0, nb); idle(2);
    chk("R11 stalled length", nb, NSRC + 1);
    chk("R11 count", q_num.size(), 2);
    if (q_num.size() == 2) begin
      chk("R11 trigger first", q_num[0], BASE + 7);
      chk("R11 scan second", q_num[1], BASE + 2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_range();
    t_masked_unmask();
    t_trigger();
    t_bad_write();
    t_resend();
    t_stall();
    idle(3);
    finish_run();
  end
endmodule